// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns an already-unpacked floating-point operand into a signed two's-complement integer of `INT_W` bits (32 or 64). The operand arrives as a class code, a sign bit, a signed unbiased exponent and a normalised mantissa. The mantissa's leading one sits at bit `MANT_W-1`, so the value is `mant * 2^(exp - (MANT_W-1))`.

The conversion always chops toward zero and takes no rounding-mode input. Any fraction bits that are dropped raise an inexact flag. Values that do not fit, infinities and NaNs saturate to the largest value of the operand's sign and raise an invalid flag. The range test is asymmetric, so the most negative integer converts cleanly.

The block registers its outputs once, so a result appears one clock after its operand.

Top module: `f2i_trunc`

## Requirements
- R1: Class code 0 (zero) gives result 0 with both flags low.
- R2: For class code 1 (number) in range, the result is the magnitude truncated toward zero, two's-complement negated when the sign is 1.
- R3: For an in-range number, inexact is 1 exactly when nonzero bits were discarded by the truncation. Invalid is 0.
- R4: A number with a negative exponent gives result 0, with inexact set when the mantissa is nonzero.
- R5: A number with exponent greater than or equal to `INT_W` is out of range.
- R6: After truncation, a magnitude at or above `2^(INT_W-1) + sign` is out of range. A negative magnitude of exactly `2^(INT_W-1)` is accepted as `0x80..0`, with or without discarded fraction bits.
- R7: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 are out of range.
- R8: An out-of-range operand gives `2^(INT_W-1)-1 + sign` (`0x7F..F` for positive, `0x80..0` for negative), sets invalid and clears inexact.
- R9: Outputs change one clock after the operand. While reset is low, the outputs are 0 with both flags low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cls_i | input | 3 | Operand class code |
| sign_i | input | 1 | Operand sign, 1 = negative |
| exp_i | input | EXP_W | Signed unbiased exponent |
| mant_i | input | MANT_W | Normalised mantissa, leading one at the top bit |
| result_o | output | INT_W | Converted integer |
| inexact_o | output | 1 | Fraction bits were discarded |
| invalid_o | output | 1 | Operand saturated |

## Verification
The hardest situation to reach is the negative boundary. Exponent `INT_W-1` with only the leading mantissa bit set must be accepted, while the same operand with a positive sign must saturate. A negative operand whose fraction bits spill below that boundary must still be accepted, but with inexact set. Random operands almost never land on these cases, so the stimulus builds them directly. Those mantissas are placed next to exponents `INT_W-1` and `INT_W`, and the reference model then judges each result on its own terms.

// File: rtl/f2i_trunc.sv
module f2i_trunc #(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 12,
  parameter int MANT_W = 56
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               cls_i,
  input  logic                     sign_i,
  input  logic signed [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0]        mant_i,
  output logic [INT_W-1:0]         result_o,
  output logic                     inexact_o,
  output logic                     invalid_o
);
  localparam int SH_W = $clog2(MANT_W + 1);

  logic              is_zero, is_num, exp_neg, exp_big, lost, ovf;
  logic [SH_W-1:0]   sh;
  logic [MANT_W-1:0] shifted;
  logic [INT_W:0]    mag, bound;
  logic [INT_W-1:0]  sat, value;

  assign is_zero = (cls_i == 3'd0);
  assign is_num  = (cls_i == 3'd1);
  assign exp_neg = exp_i[EXP_W-1];
  assign exp_big = (exp_i >= $signed(EXP_W'(INT_W)));
  assign sh      = SH_W'(MANT_W - 1) - exp_i[SH_W-1:0];
  assign shifted = mant_i >> sh;

  always_comb begin
    if (exp_neg) begin
      mag  = '0;
      lost = |mant_i;
    end else begin
      mag  = shifted[INT_W:0];
      lost = ((shifted << sh) != mant_i);
    end
  end

  assign bound = {1'b1, {INT_W{1'b0}}} >> 1;
  assign ovf   = !is_zero && (!is_num || exp_big || (mag >= bound + (INT_W+1)'(sign_i)));
  assign sat   = {1'b0, {(INT_W-1){1'b1}}} + INT_W'(sign_i);
  assign value = sign_i ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o  <= '0;
      inexact_o <= 1'b0;
      invalid_o <= 1'b0;
    end else if (is_zero) begin
      result_o  <= '0;
      inexact_o <= 1'b0;
      invalid_o <= 1'b0;
    end else if (ovf) begin
      result_o  <= sat;
      inexact_o <= 1'b0;
      invalid_o <= 1'b1;
    end else begin
      result_o  <= value;
      inexact_o <= lost;
      invalid_o <= 1'b0;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  p_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cls_i) == 3'd0) |-> (result_o == '0 && !inexact_o && !invalid_o));

  p_nonnum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cls_i) > 3'd1) |-> invalid_o);

  p_bigexp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cls_i) == 3'd1 && !$past(exp_i[EXP_W-1]) &&
     $past(exp_i) >= $signed(EXP_W'(INT_W))) |-> invalid_o);

  p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> (!inexact_o && result_o[INT_W-2:0] == {(INT_W-1){~result_o[INT_W-1]}}));

  p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !invalid_o && result_o != '0) |-> (result_o[INT_W-1] == $past(sign_i)));

  p_negexp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cls_i) == 3'd1 && $past(exp_i[EXP_W-1])) |-> (result_o == '0 && !invalid_o));
endmodule

// File: tb/f2i_trunc_tb.sv
module f2i_trunc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cls = 3'd0;
  logic        sgn = 1'b0;
  logic signed [11:0] ex = '0;
  logic [55:0] mant = '0;
  logic [31:0] res;
  logic        inx, inv;
  int applied = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  f2i_trunc u_dut (.clk(clk), .rst_n(rst_n), .cls_i(cls), .sign_i(sgn), .exp_i(ex),
                   .mant_i(mant), .result_o(res), .inexact_o(inx), .invalid_o(inv));

  task automatic model(input logic [2:0] c, input logic s, input int e, input longint unsigned m,
                       output logic [31:0] er, output logic ei, output logic ev);
    longint unsigned div, q, r, lim;
    bit over;
    er = 0; ei = 0; ev = 0; over = 0; q = 0; r = 0;
    if (c == 0) return;
    if (c != 1) over = 1;
    else if (e >= 32) over = 1;
    else if (e < 0) begin q = 0; r = m; end
    else begin
      div = 64'd1 << (55 - e);
      q = m / div;
      r = m % div;
    end
    lim = 64'h8000_0000 + longint'(s);
    if (!over && q >= lim) over = 1;
    if (over) begin
      er = s ? 32'h8000_0000 : 32'h7FFF_FFFF;
      ev = 1;
    end else begin
      er = s ? 32'(-q) : 32'(q);
      ei = (r != 0);
    end
  endtask

  task automatic apply(input string tag, input logic [2:0] c, input logic s, input int e,
                       input longint unsigned m);
    logic [31:0] er; logic ei, ev;
    cls = c; sgn = s; ex = 12'(e); mant = 56'(m);
    model(c, s, e, m, er, ei, ev);
    @(negedge clk);
    applied++;
    if (res !== er || inx !== ei || inv !== ev) begin
      bad++;
      $display("FAIL %s: got %h inx=%b inv=%b, expected %h inx=%b inv=%b", tag, res, inx, inv, er, ei, ev);
    end
  endtask

  localparam longint unsigned ONE = 64'd1 << 55;

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    cls = 3'd1; sgn = 1'b1; ex = 12'sd40; mant = 56'(ONE);
    @(negedge clk); @(negedge clk);
    applied++;
    if (res !== 0 || inx !== 0 || inv !== 0) begin
      bad++;
      $display("FAIL R9 reset: got %h %b %b, expected 0 0 0", res, inx, inv);
    end
    rst_n = 1'b1;
    apply("R1 zero", 3'd0, 1'b1, 5, ONE);
    apply("R2 one", 3'd1, 1'b0, 0, ONE);
    apply("R2 minus one", 3'd1, 1'b1, 0, ONE);
    apply("R2 R3 2.5", 3'd1, 1'b0, 1, ONE | (ONE >> 2));
    apply("R2 R3 -7.75", 3'd1, 1'b1, 2, ONE | (ONE >> 1) | (ONE >> 2) | (ONE >> 3) | (ONE >> 4));
    apply("R3 exact 12", 3'd1, 1'b0, 3, ONE | (ONE >> 1));
    apply("R4 half", 3'd1, 1'b0, -1, ONE);
    apply("R4 tiny neg", 3'd1, 1'b1, -30, ONE | 64'd1);
    apply("R5 exp32", 3'd1, 1'b0, 32, ONE);
    apply("R5 exp40 neg", 3'd1, 1'b1, 40, ONE);
    apply("R6 -2^31 exact", 3'd1, 1'b1, 31, ONE);
    apply("R6 +2^31", 3'd1, 1'b0, 31, ONE);
    apply("R6 -2^31 frac", 3'd1, 1'b1, 31, ONE | 64'd1);
    apply("R6 -(2^31+1)", 3'd1, 1'b1, 31, ONE | (64'd1 << 24));
    apply("R6 max pos frac", 3'd1, 1'b0, 30, 64'hFF_FFFF_FFFF_FFFF);
    apply("R7 inf", 3'd2, 1'b0, 0, ONE);
    apply("R7 qnan neg", 3'd3, 1'b1, 0, ONE);
    apply("R7 snan", 3'd4, 1'b0, 0, ONE);
    apply("R7 code7", 3'd7, 1'b1, 0, ONE);
    apply("R8 after inexact", 3'd1, 1'b0, 1, ONE | 64'd3);
    apply("R8 ovf clears inx", 3'd1, 1'b0, 33, ONE | 64'd3);
    for (int i = 0; i < 400; i++) begin
      longint unsigned m;
      int e;
      m = ONE | ({longint'($urandom), 32'($urandom)} & (ONE - 1));
      e = int'($urandom % 40) - 4;
      apply("R2 R3 R6 random", ($urandom % 8 == 0) ? 3'(($urandom % 8)) : 3'd1, 1'($urandom), e, m);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule